// File: doc/BRIEF.md
# SPI TPM Transaction Host Engine

This block is an SPI master that carries out one complete register access to a TPM-style device. A one-cycle start pulse starts the access. The pulse comes with a direction flag, a 16-bit register address, a byte count and a flag that marks a chunked read. The engine first screens the byte count. It then pulls chip select low and shifts out a four-byte command header. After the header it honours the device's flow-control flag: the device can hold the access in a wait state, and the engine polls with zero bytes until the device reports ready.

After the wait phase the engine moves the data bytes. Write data is taken from a byte-wide source that is advanced by a pop strobe. Read data is handed out one byte at a time with a valid strobe. Every access ends with a one-cycle done pulse. Two flags come with that pulse: a timeout flag when the device never became ready, and a bad-length flag when the request was refused before any bus activity.

Top module: `tpm_spi_host`

## Requirements
- R1: The first header byte has bit 7 set to 1 for a read and 0 for a write. Bits 6:0 hold the byte count minus one.
- R2: The second header byte is 0xD4. The third and fourth header bytes are the register address, high byte first.
- R3: If bit 0 of the byte received during the fourth header byte is 1, the data phase follows at once and no poll byte is sent.
- R4: Otherwise the engine sends 0x00 poll bytes. It looks only at bit 0 of each received byte and enters the data phase after the first poll byte whose bit 0 is 1.
- R5: After 50 poll bytes with bit 0 equal to 0, the access ends. Done is pulsed with the timeout flag set, and no data byte is moved.
- R6: A byte count of 0 or above 128 is refused. Done is pulsed with the bad-length flag set, and neither chip select nor the serial clock toggles.
- R7: When the chunked-read flag is 1 on a read, only counts of 1, 2 and 4 are accepted. Any other count is refused as in R6. The flag has no effect on writes.
- R8: A write sends exactly the requested number of data bytes. Each byte is the value on the write-data input when the pop strobe is high, with one pop per byte.
- R9: A read sends 0x00 data bytes. It gives exactly the requested number of valid strobes, each carrying the byte received at that point, in order.
- R10: Chip select goes low once before the first header bit and stays low through the wait phase up to the last data bit. It rises once at the end of every access, including a timeout. Done is a single-cycle pulse, and chip select is high when done is seen.
- R11: The bus uses SPI mode 0 with MSB first. The serial clock idles low, is low whenever chip select changes, and gives exactly eight rising edges per byte.
- R12: A start pulse that arrives while an access is in progress is ignored, along with its inputs. The request inputs are captured only when an access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for one access |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 16 | Device register address |
| xfer_len | input | 8 | Data byte count |
| chunk_rd | input | 1 | Restricts read counts to 1, 2 or 4 |
| wr_data | input | 8 | Next write byte from the source |
| wr_pop | output | 1 | Write byte taken, advance the source |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished (one cycle) |
| err_timeout | output | 1 | Device never became ready |
| err_len | output | 1 | Request refused for its byte count |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The assertions check several relations on every cycle:
- the shift engine runs only while chip select is low, and the serial clock rests low when it is idle;
- the shift engine is never relaunched mid-byte;
- the two error flags never occur together, and a refused request leaves chip select high;
- a start pulse during an access leaves the captured request unchanged.

The byte-level content can only be shown by the scenarios, using a device model that replies with chosen wait lengths and data patterns. That content covers the header encoding, the poll sequence, the 50-poll boundary (49 waits succeed, more time out), the 128-byte and zero-length limits, the chunk-length screening, and the exact data byte counts.

// File: rtl/tsh_pkg.sv
package tsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_POLL = 2'd2,
    ST_DATA = 2'd3
  } tsh_state_e;

  localparam logic [7:0] HDR_TAG = 8'hD4;
  localparam int         HDR_BYTES = 4;
endpackage

// File: rtl/tsh_shifter.sv
// One-byte SPI mode-0 shifter with a clock divider; MSB first.
module tsh_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic          busy_q, busy_d, sclk_q, sclk_d, done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (go && !busy_q) begin
      busy_d = 1'b1;
      tx_d   = tx_byte;
      cnt_d  = '0;
      bit_d  = '0;
      sclk_d = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
        end else begin
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  assert_idle_sclk_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q) else $error("sclk high while shifter idle");
  assert_no_relaunch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q) else $error("byte launched while shifting");
endmodule

// File: rtl/tsh_ctrl.sv
// Access sequencer: length screening, header, wait-state polling, data phase.
module tsh_ctrl
  import tsh_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int MAX_LEN = 128,
  parameter int RETRIES = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_nwr,
  input  logic [15:0]      reg_addr,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             chunk_rd,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  input  logic [7:0]       wr_data,
  output logic             wr_pop,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             err_timeout,
  output logic             err_len,
  output logic             cs_n
);
  localparam int PW = (RETRIES > 1) ? $clog2(RETRIES) : 1;
  localparam logic [PW-1:0]    POLL_LAST = PW'(RETRIES - 1);
  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] HDR_LAST  = LEN_W'(HDR_BYTES - 1);

  tsh_state_e       st_q, st_d;
  logic [LEN_W-1:0] idx_q, idx_d, len_q, len_d, len_m1;
  logic [PW-1:0]    poll_q, poll_d;
  logic [15:0]      addr_q, addr_d;
  logic             rd_q, rd_d, go_q, go_d, done_q, done_d;
  logic             to_q, to_d, el_q, el_d, csn_q, csn_d, len_bad, chunk_ok;

  assign len_m1   = len_q - 1'b1;
  assign chunk_ok = (xfer_len == LEN_W'(1)) || (xfer_len == LEN_W'(2)) ||
                    (xfer_len == LEN_W'(4));
  assign len_bad  = (xfer_len == '0) || (xfer_len > LEN_MAX) ||
                    (chunk_rd && rd_nwr && !chunk_ok);

  always_comb begin
    sh_tx = 8'h00;
    case (st_q)
      ST_HDR: begin
        case (idx_q[1:0])
          2'd0:    sh_tx = {rd_q, len_m1[6:0]};
          2'd1:    sh_tx = HDR_TAG;
          2'd2:    sh_tx = addr_q[15:8];
          default: sh_tx = addr_q[7:0];
        endcase
      end
      ST_DATA: sh_tx = rd_q ? 8'h00 : wr_data;
      default: sh_tx = 8'h00;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    len_d  = len_q;
    poll_d = poll_q;
    addr_d = addr_q;
    rd_d   = rd_q;
    to_d   = to_q;
    el_d   = el_q;
    csn_d  = csn_q;
    go_d   = 1'b0;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        if (len_bad) begin
          done_d = 1'b1;
          el_d   = 1'b1;
          to_d   = 1'b0;
        end else begin
          st_d   = ST_HDR;
          idx_d  = '0;
          len_d  = xfer_len;
          addr_d = reg_addr;
          rd_d   = rd_nwr;
          el_d   = 1'b0;
          to_d   = 1'b0;
          csn_d  = 1'b0;
          go_d   = 1'b1;
        end
      end
      ST_HDR: if (sh_done) begin
        go_d = 1'b1;
        if (idx_q == HDR_LAST) begin
          idx_d  = '0;
          poll_d = '0;
          st_d   = sh_rx[0] ? ST_DATA : ST_POLL;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_POLL: if (sh_done) begin
        if (sh_rx[0]) begin
          st_d = ST_DATA;
          go_d = 1'b1;
        end else if (poll_q == POLL_LAST) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          to_d   = 1'b1;
          csn_d  = 1'b1;
        end else begin
          poll_d = poll_q + 1'b1;
          go_d   = 1'b1;
        end
      end
      default: if (sh_done) begin
        if (idx_q == len_m1) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          csn_d  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          go_d  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      len_q  <= '0;
      poll_q <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      to_q   <= 1'b0;
      el_q   <= 1'b0;
      csn_q  <= 1'b1;
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
      poll_q <= poll_d;
      addr_q <= addr_d;
      rd_q   <= rd_d;
      to_q   <= to_d;
      el_q   <= el_d;
      csn_q  <= csn_d;
      go_q   <= go_d;
      done_q <= done_d;
    end
  end

  assign sh_go       = go_q;
  assign wr_pop      = go_q && (st_q == ST_DATA) && !rd_q;
  assign rd_valid    = sh_done && (st_q == ST_DATA) && rd_q;
  assign rd_data     = sh_rx;
  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign err_timeout = to_q;
  assign err_len     = el_q;
  assign cs_n        = csn_q;

  assert_len_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && el_q) |-> (csn_q && $past(csn_q))) else $error("bus touched on bad length");
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(to_q && el_q)) else $error("both error flags set");
  assert_cs_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> !csn_q) else $error("chip select released mid access");
  assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && start) |=> ($stable(addr_q) && $stable(len_q) && $stable(rd_q)))
    else $error("request changed while busy");
endmodule

// File: rtl/tpm_spi_host.sv
module tpm_spi_host #(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 8,
  parameter int MAX_LEN  = 128,
  parameter int RETRIES  = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_nwr,
  input  logic [15:0]      reg_addr,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             chunk_rd,
  input  logic [7:0]       wr_data,
  output logic             wr_pop,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             err_timeout,
  output logic             err_len,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  logic       rst_meta, rst_sync_n;
  logic       sh_go, sh_done, sh_busy;
  logic [7:0] sh_tx, sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tsh_ctrl #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .RETRIES(RETRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .rd_nwr(rd_nwr),
    .reg_addr(reg_addr), .xfer_len(xfer_len), .chunk_rd(chunk_rd),
    .sh_done(sh_done), .sh_rx(sh_rx), .sh_go(sh_go), .sh_tx(sh_tx),
    .wr_data(wr_data), .wr_pop(wr_pop), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .err_timeout(err_timeout), .err_len(err_len),
    .cs_n(cs_n)
  );

  tsh_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .go(sh_go), .tx_byte(sh_tx), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx)
  );

  assert_shift_in_cs_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sh_busy |-> !cs_n) else $error("shifting with chip select high");
endmodule

// File: tb/test_tpm_spi_host.sv
module test_tpm_spi_host;
  localparam int CLK_PERIOD = 10;
  localparam int RETRIES    = 50;

  logic clk, rst_n, start, rd_nwr, chunk_rd, miso;
  logic [15:0] reg_addr;
  logic [7:0]  xfer_len, wr_data, rd_data;
  logic wr_pop, rd_valid, busy, done, err_timeout, err_len, sclk, cs_n, mosi;

  tpm_spi_host i_tpm_spi_host (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .reg_addr(reg_addr),
    .xfer_len(xfer_len), .chunk_rd(chunk_rd), .wr_data(wr_data), .wr_pop(wr_pop),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .err_timeout(err_timeout), .err_len(err_len), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_mosi[$];
  string      exp_tag[$];
  logic [7:0] exp_rd[$];
  int cur_wait = 0;
  logic [7:0] cur_base = 8'h00;
  int dev_bit = 0, dev_k = 0, wr_idx = 0, rd_cnt = 0;
  int cs_falls = 0, cs_rises = 0, sclk_rises = 0;
  logic [7:0] dev_sr = 8'h00, dev_rx = 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  function automatic logic [7:0] rd_pat(input int i);
    return cur_base + 8'(i * 29);
  endfunction
  function automatic logic [7:0] wr_pat(input int i);
    return cur_base ^ 8'(i * 51);
  endfunction

  // Device model reply for byte k of the current access
  function automatic logic [7:0] resp(input int k);
    int d0;
    if (k < 3) return 8'hA6;
    if (k == 3) return (cur_wait == 0) ? 8'h81 : 8'hFE;
    if (cur_wait == 0) d0 = 4;
    else begin
      if (k - 4 < cur_wait) return 8'hFE;
      if (k - 4 == cur_wait) return 8'h01;
      d0 = 5 + cur_wait;
    end
    return rd_pat(k - d0);
  endfunction

  assign miso    = dev_sr[7];
  assign wr_data = wr_pat(wr_idx);

  always @(posedge clk) if (wr_pop) wr_idx <= wr_idx + 1;

  always @(negedge cs_n) begin
    cs_falls++;
    check(sclk == 1'b0, "R11", "sclk at chip select fall", sclk, 0);
    dev_k   = 0;
    dev_bit = 0;
    dev_sr  = resp(0);
  end
  always @(posedge cs_n) begin
    cs_rises++;
    check(sclk == 1'b0, "R11", "sclk at chip select rise", sclk, 0);
  end

  // Monitor: compare each byte seen on MOSI with the scoreboard
  always @(posedge sclk) begin
    sclk_rises++;
    if (cs_n) check(1'b0, "R10", "sclk rise with cs_n high", 1, 0);
    dev_rx = {dev_rx[6:0], mosi};
    dev_bit++;
    if (dev_bit == 8) begin
      if (exp_mosi.size() == 0) check(1'b0, "R8", "unexpected MOSI byte", dev_rx, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_mosi.pop_front();
        t = exp_tag.pop_front();
        check(dev_rx == e, t, "MOSI byte", dev_rx, e);
      end
    end
  end
  always @(negedge sclk) if (!cs_n) begin
    if (dev_bit == 8) begin
      dev_k++;
      dev_bit = 0;
      dev_sr  = resp(dev_k);
    end else dev_sr = {dev_sr[6:0], 1'b0};
  end

  always @(negedge clk) if (rd_valid) begin
    rd_cnt++;
    if (exp_rd.size() == 0) check(1'b0, "R9", "unexpected read byte", rd_data, 0);
    else begin
      logic [7:0] e;
      e = exp_rd.pop_front();
      check(rd_data == e, "R9", "read byte", rd_data, e);
    end
  end

  // err_kind: 0 ok, 1 timeout, 2 bad length
  task automatic run(input bit rd, input logic [15:0] addr, input int len,
                     input bit chunk, input int wait_n, input logic [7:0] base,
                     input int err_kind, input string etag, input bit poke);
    int polls, nbytes, f0, r0, s0, cyc;
    cur_wait = wait_n;
    cur_base = base;
    wr_idx   = 0;
    rd_cnt   = 0;
    polls    = (wait_n == 0) ? 0 : ((wait_n >= RETRIES) ? RETRIES : wait_n + 1);
    nbytes   = 0;
    if (err_kind != 2) begin
      exp_mosi.push_back({rd, 7'(len - 1)}); exp_tag.push_back("R1");
      exp_mosi.push_back(8'hD4);             exp_tag.push_back("R2");
      exp_mosi.push_back(addr[15:8]);        exp_tag.push_back("R2");
      exp_mosi.push_back(addr[7:0]);         exp_tag.push_back(wait_n == 0 ? "R3" : "R2");
      for (int i = 0; i < polls; i++) begin
        exp_mosi.push_back(8'h00); exp_tag.push_back(wait_n >= RETRIES ? "R5" : "R4");
      end
      nbytes = 4 + polls;
      if (err_kind == 0) begin
        for (int i = 0; i < len; i++) begin
          exp_mosi.push_back(rd ? 8'h00 : wr_pat(i));
          exp_tag.push_back(rd ? "R9" : "R8");
          if (rd) exp_rd.push_back(rd_pat(i));
        end
        nbytes += len;
      end
    end
    f0 = cs_falls; r0 = cs_rises; s0 = sclk_rises;
    @(negedge clk);
    start = 1'b1; rd_nwr = rd; reg_addr = addr; xfer_len = 8'(len); chunk_rd = chunk;
    @(negedge clk);
    start = 1'b0; reg_addr = ~addr; xfer_len = 8'd3; rd_nwr = ~rd;
    if (poke) begin
      repeat (40) @(negedge clk);
      check(busy == 1'b1, "R12", "busy during access", busy, 1);
      start = 1'b1; reg_addr = 16'hBEEF; xfer_len = 8'd7;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc <= 20000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc <= 20000, "R10", "done reached", cyc, 0);
    check(err_timeout == (err_kind == 1), "R5", "timeout flag", err_timeout, err_kind == 1);
    check(err_len == (err_kind == 2), etag, "length flag", err_len, err_kind == 2);
    check(cs_n == 1'b1, "R10", "cs_n high at done", cs_n, 1);
    @(negedge clk);
    check(done == 1'b0, "R10", "done single cycle", done, 0);
    check(exp_mosi.size() == 0, "R8", "MOSI bytes left", exp_mosi.size(), 0);
    check(exp_rd.size() == 0, "R9", "read bytes left", exp_rd.size(), 0);
    check(rd_cnt == ((rd && err_kind == 0) ? len : 0), "R9", "read strobes", rd_cnt,
          (rd && err_kind == 0) ? len : 0);
    check(wr_idx == ((!rd && err_kind == 0) ? len : 0), "R8", "write pops", wr_idx,
          (!rd && err_kind == 0) ? len : 0);
    check(cs_falls - f0 == (err_kind == 2 ? 0 : 1), err_kind == 2 ? "R6" : "R10",
          "cs_n falls", cs_falls - f0, err_kind == 2 ? 0 : 1);
    check(cs_rises - r0 == (err_kind == 2 ? 0 : 1), "R10", "cs_n rises",
          cs_rises - r0, err_kind == 2 ? 0 : 1);
    check(sclk_rises - s0 == 8 * nbytes, "R11", "sclk rising edges",
          sclk_rises - s0, 8 * nbytes);
    exp_mosi.delete(); exp_tag.delete(); exp_rd.delete();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_nwr = 1'b0; chunk_rd = 1'b0;
    reg_addr = '0; xfer_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_falls = 0; cs_rises = 0; sclk_rises = 0;
    check(cs_n == 1'b1, "R10", "reset cs_n", cs_n, 1);
    check(sclk == 1'b0, "R11", "reset sclk", sclk, 0);
    check(busy == 1'b0 && done == 1'b0, "R10", "reset busy/done", {busy, done}, 0);

    run(1'b0, 16'h0F18, 1,   1'b0, 0,  8'h3C, 0, "R6", 1'b0); // R1 R3 R8 write
    run(1'b1, 16'h0024, 4,   1'b1, 0,  8'h51, 0, "R7", 1'b0); // R7 chunk read ok
    run(1'b0, 16'hA5C3, 3,   1'b0, 5,  8'h90, 0, "R6", 1'b0); // R4 wait
    run(1'b1, 16'h1234, 2,   1'b0, 49, 8'h0E, 0, "R6", 1'b0); // R4 last poll ready
    run(1'b1, 16'h4321, 4,   1'b0, 60, 8'h22, 1, "R6", 1'b0); // R5 timeout
    run(1'b0, 16'h0001, 0,   1'b0, 0,  8'h00, 2, "R6", 1'b0); // R6 zero
    run(1'b1, 16'h0002, 129, 1'b0, 0,  8'h00, 2, "R6", 1'b0); // R6 too long
    run(1'b0, 16'h7F00, 128, 1'b0, 0,  8'hC7, 0, "R6", 1'b0); // R6 boundary ok
    run(1'b1, 16'h0F00, 3,   1'b1, 0,  8'h00, 2, "R7", 1'b0); // R7 bad chunk
    run(1'b0, 16'h0F04, 3,   1'b1, 2,  8'h6B, 0, "R7", 1'b0); // R7 write unaffected
    run(1'b1, 16'h0F80, 6,   1'b0, 3,  8'h18, 0, "R12", 1'b1); // R12 start while busy
    summary();
    $finish;
  end
endmodule